// File: doc/BRIEF.md
# Cache Miss Classification Unit

This block is the tag directory of a small physically tagged, two-way set-associative cache with least-recently-used replacement. It takes a stream of valid-qualified physical byte addresses. For each one it reports whether the access hits. For a miss it also reports why the miss happened. It does not store data, handle writes, talk to memory or translate addresses. Its job is to decide placement and to explain each miss.

Two side structures run next to the real directory. The first is a one-bit-per-block record of every block number ever referenced. The second is a fully associative LRU shadow directory that holds the same total number of blocks as the cache. A miss is classified as follows:
- compulsory, if the block was never referenced before;
- capacity, if the block was referenced before but is no longer in the shadow directory;
- conflict, otherwise.

Each classification uses the state before the access. Two running counters, one for accesses and one for hits, let an observer compute the hit ratio.

A preload pulse resets the unit to a known warm state. In that state the first eight block numbers have been accessed in ascending order.

Top module: `cmc_top`

## Requirements
- R1: After reset, resp_valid_o is 0, both counters read 0, every way is invalid, and every block counts as never seen.
- R2: An address splits into byte offset [2:0], set index [4:3] and tag [13:5]. The block number is bits [13:3]. Two addresses in the same block hit identically whatever their offsets.
- R3: Within a set, the victim on a miss is the least recently used way. A hit makes the hit way the most recently used.
- R4: On a miss, an invalid way is filled before any valid way is evicted. Way 0 is filled before way 1.
- R5: A miss to a block number that was never referenced since reset or preload reports miss_class_o = 01 (compulsory).
- R6: A miss to a previously referenced block reports miss_class_o = 10 (capacity) when that block is not among the 8 most recently referenced distinct blocks.
- R7: Any other miss reports miss_class_o = 11 (conflict).
- R8: A preload pulse clears all tracking state. It then installs block numbers 0 to 7 as if they were accessed in ascending order. Block b goes to set b mod 4, way b div 4, with tag b div 4, and way 0 is marked as the LRU way. Blocks 0 to 7 count as seen. Block 7 is the most recent and block 0 the least recent in the shadow directory.
- R9: Every accepted request produces exactly one response, in the next cycle. A hit carries miss_class_o = 00. way_o is the hit way, or the way filled on a miss.
- R10: evict_valid_o is 1 only on a miss that replaces a valid way. evict_tag_o then holds that way's old tag.
- R11: access_cnt_o and hit_cnt_o count accepted requests and hits, and saturate at all-ones. A preload leaves both unchanged.
- R12: When preload_i and req_valid_i are high in the same cycle, the preload takes effect and the request is dropped: no response and no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| preload_i | input | 1 | Install the warm state (R8) |
| req_valid_i | input | 1 | Request strobe |
| req_addr_i | input | 14 | Physical byte address |
| resp_valid_o | output | 1 | Response strobe, one cycle after the request |
| hit_o | output | 1 | Access hit |
| miss_class_o | output | 2 | 00 hit, 01 compulsory, 10 capacity, 11 conflict |
| way_o | output | 1 | Hit way or filled way |
| evict_valid_o | output | 1 | A valid block was replaced |
| evict_tag_o | output | 9 | Tag of the replaced block |
| access_cnt_o | output | 16 | Saturating access count |
| hit_cnt_o | output | 16 | Saturating hit count |

## Verification
The bench builds the block with its default parameters: 14-bit addresses, 8-byte blocks, 4 sets, an 8-entry shadow and 16-bit counters. With 4 sets, a random block range of about two dozen numbers produces a steady mix of all three miss classes. A 16-bit counter width makes saturation reachable with about 65 thousand back-to-back hits, well inside the run length. The warm state after preload lets a known 15-access trace, covering hits, compulsory, capacity and conflict misses, be checked against fixed expected classes.

// File: rtl/cmc_pkg.sv
package cmc_pkg;
  typedef enum logic [1:0] {
    MC_NONE = 2'b00,
    MC_COMP = 2'b01,
    MC_CAP  = 2'b10,
    MC_CONF = 2'b11
  } miss_class_e;
endpackage

// File: rtl/cmc_set_dir.sv
module cmc_set_dir #(
  parameter int IDX_W = 2,
  parameter int TAG_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             upd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [TAG_W-1:0] tag_i,
  output logic             hit_o,
  output logic             way_o,
  output logic             victim_valid_o,
  output logic [TAG_W-1:0] victim_tag_o
);
  localparam int NSETS = 1 << IDX_W;
  localparam int NWAYS = 2;

  logic [NSETS-1:0][NWAYS-1:0][TAG_W-1:0] tag_a;
  logic [NSETS-1:0][NWAYS-1:0]            vld_a;
  logic [NSETS-1:0]                       lru_a;

  logic [NWAYS-1:0] hit_w;
  logic             way_sel;

  always_comb begin
    for (int w = 0; w < NWAYS; w++)
      hit_w[w] = vld_a[idx_i][w] && (tag_a[idx_i][w] == tag_i);
    if (|hit_w)                  way_sel = hit_w[1];
    else if (!vld_a[idx_i][0])   way_sel = 1'b0;
    else if (!vld_a[idx_i][1])   way_sel = 1'b1;
    else                         way_sel = lru_a[idx_i];
  end

  assign hit_o          = |hit_w;
  assign way_o          = way_sel;
  assign victim_valid_o = !(|hit_w) && vld_a[idx_i][way_sel];
  assign victim_tag_o   = victim_valid_o ? tag_a[idx_i][way_sel] : '0;

  for (genvar s = 0; s < NSETS; s++) begin : g_set
    logic [NWAYS-1:0][TAG_W-1:0] tag_q;
    logic [NWAYS-1:0]            vld_q;
    logic                        lru_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        tag_q <= '0;
        vld_q <= '0;
        lru_q <= 1'b0;
      end else if (preload_i) begin
        // block w*NSETS+s lands in way w with tag w; way 0 was touched first
        for (int w = 0; w < NWAYS; w++) tag_q[w] <= TAG_W'(w);
        vld_q <= '1;
        lru_q <= 1'b0;
      end else if (upd_i && (idx_i == IDX_W'(s))) begin
        tag_q[way_sel] <= tag_i;
        vld_q[way_sel] <= 1'b1;
        lru_q          <= ~way_sel;
      end
    end

    assign tag_a[s] = tag_q;
    assign vld_a[s] = vld_q;
    assign lru_a[s] = lru_q;
  end
endmodule

// File: rtl/cmc_shadow.sv
module cmc_shadow #(
  parameter int BLK_W = 11,
  parameter int DEPTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             upd_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             present_o
);
  localparam int POS_W = $clog2(DEPTH);

  logic [DEPTH-1:0][BLK_W-1:0] ent_a;
  logic [DEPTH-1:0]            vld_a;
  logic [DEPTH-1:0]            match;
  logic [POS_W-1:0]            pos;

  // pos: slot that leaves the stack (match, else the oldest slot)
  always_comb begin
    pos = POS_W'(DEPTH - 1);
    for (int i = DEPTH - 1; i >= 0; i--) begin
      match[i] = vld_a[i] && (ent_a[i] == blk_i);
      if (match[i]) pos = POS_W'(i);
    end
  end

  assign present_o = |match;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [BLK_W-1:0] ent_q;
    logic             vld_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_q <= '0;
        vld_q <= 1'b0;
      end else if (preload_i) begin
        ent_q <= BLK_W'(DEPTH - 1 - i);
        vld_q <= 1'b1;
      end else if (upd_i) begin
        if (i == 0) begin
          ent_q <= blk_i;
          vld_q <= 1'b1;
        end else if (POS_W'(i) <= pos) begin
          ent_q <= ent_a[(i > 0) ? i - 1 : 0];
          vld_q <= vld_a[(i > 0) ? i - 1 : 0];
        end
      end
    end

    assign ent_a[i] = ent_q;
    assign vld_a[i] = vld_q;
  end
endmodule

// File: rtl/cmc_seen.sv
module cmc_seen #(
  parameter int BLK_W = 11,
  parameter int NBLK  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             preload_i,
  input  logic             upd_i,
  input  logic [BLK_W-1:0] blk_i,
  output logic             seen_o
);
  localparam int SEEN_N = 1 << BLK_W;

  logic [SEEN_N-1:0] seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        seen_q <= '0;
    else if (preload_i) seen_q <= {{(SEEN_N - NBLK){1'b0}}, {NBLK{1'b1}}};
    else if (upd_i)     seen_q[blk_i] <= 1'b1;
  end

  assign seen_o = seen_q[blk_i];
endmodule

// File: rtl/cmc_sat_cnt.sv
module cmc_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (inc_i && !(&cnt_o))   cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/cmc_top.sv
module cmc_top
  import cmc_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 3,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 16,
  localparam int BLK_W = ADDR_W - OFF_W,
  localparam int TAG_W = BLK_W - IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              preload_i,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic [1:0]        miss_class_o,
  output logic              way_o,
  output logic              evict_valid_o,
  output logic [TAG_W-1:0]  evict_tag_o,
  output logic [CNT_W-1:0]  access_cnt_o,
  output logic [CNT_W-1:0]  hit_cnt_o
);
  localparam int NSETS = 1 << IDX_W;
  localparam int NBLK  = NSETS * 2;

  logic [BLK_W-1:0] blk;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic             acc;
  logic             dir_hit, dir_way, vic_valid, seen, present;
  logic [TAG_W-1:0] vic_tag;
  miss_class_e      cls;

  assign blk = req_addr_i[ADDR_W-1:OFF_W];
  assign idx = blk[IDX_W-1:0];
  assign tag = blk[BLK_W-1:IDX_W];
  assign acc = req_valid_i && !preload_i;

  cmc_set_dir #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_dir (
    .clk_i, .rst_ni, .preload_i, .upd_i(acc), .idx_i(idx), .tag_i(tag),
    .hit_o(dir_hit), .way_o(dir_way), .victim_valid_o(vic_valid), .victim_tag_o(vic_tag)
  );

  cmc_shadow #(.BLK_W(BLK_W), .DEPTH(NBLK)) u_shadow (
    .clk_i, .rst_ni, .preload_i, .upd_i(acc), .blk_i(blk), .present_o(present)
  );

  cmc_seen #(.BLK_W(BLK_W), .NBLK(NBLK)) u_seen (
    .clk_i, .rst_ni, .preload_i, .upd_i(acc), .blk_i(blk), .seen_o(seen)
  );

  cmc_sat_cnt #(.W(CNT_W)) u_acc_cnt (
    .clk_i, .rst_ni, .inc_i(acc), .cnt_o(access_cnt_o)
  );

  cmc_sat_cnt #(.W(CNT_W)) u_hit_cnt (
    .clk_i, .rst_ni, .inc_i(acc && dir_hit), .cnt_o(hit_cnt_o)
  );

  always_comb begin
    if (dir_hit)      cls = MC_NONE;
    else if (!seen)   cls = MC_COMP;
    else if (present) cls = MC_CONF;
    else              cls = MC_CAP;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o  <= 1'b0;
      hit_o         <= 1'b0;
      miss_class_o  <= MC_NONE;
      way_o         <= 1'b0;
      evict_valid_o <= 1'b0;
      evict_tag_o   <= '0;
    end else begin
      resp_valid_o <= acc;
      if (acc) begin
        hit_o         <= dir_hit;
        miss_class_o  <= cls;
        way_o         <= dir_way;
        evict_valid_o <= vic_valid;
        evict_tag_o   <= vic_tag;
      end
    end
  end
endmodule

// File: rtl/cmc_checker.sv
module cmc_checker #(
  parameter int ADDR_W = 14,
  parameter int OFF_W  = 3,
  parameter int TAG_W  = 9,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              preload_i,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic              resp_valid_o,
  input logic              hit_o,
  input logic [1:0]        miss_class_o,
  input logic              evict_valid_o,
  input logic [TAG_W-1:0]  evict_tag_o,
  input logic [CNT_W-1:0]  access_cnt_o,
  input logic [CNT_W-1:0]  hit_cnt_o
);
  logic acc;
  assign acc = req_valid_i && !preload_i;

  p_addr_known: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> !$isunknown(req_addr_i));

  p_resp_follows_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc |=> resp_valid_o);

  p_no_spurious_resp_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> !resp_valid_o);

  p_hit_class_none_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && hit_o) |-> (miss_class_o == 2'b00));

  p_miss_has_class_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !hit_o) |-> (miss_class_o != 2'b00));

  p_hit_no_evict_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && hit_o) |-> !evict_valid_o);

  p_no_evict_tag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !evict_valid_o) |-> (evict_tag_o == '0));

  p_hits_le_acc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_cnt_o <= access_cnt_o);

  p_acc_step_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !(&access_cnt_o)) |=> (access_cnt_o == $past(access_cnt_o) + CNT_W'(1)));

  p_preload_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preload_i |=> ($stable(access_cnt_o) && $stable(hit_cnt_o)));

  p_repeat_hits_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && $past(acc) && (req_addr_i[ADDR_W-1:OFF_W] == $past(req_addr_i[ADDR_W-1:OFF_W])))
      |=> hit_o);
endmodule

bind cmc_top cmc_checker #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .TAG_W(TAG_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .preload_i(preload_i), .req_valid_i(req_valid_i),
  .req_addr_i(req_addr_i), .resp_valid_o(resp_valid_o), .hit_o(hit_o),
  .miss_class_o(miss_class_o), .evict_valid_o(evict_valid_o), .evict_tag_o(evict_tag_o),
  .access_cnt_o(access_cnt_o), .hit_cnt_o(hit_cnt_o)
);

// File: tb/sim_cmc_top.sv
`timescale 1ns/1ps
module sim_cmc_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        preload = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_addr = '0;
  logic        resp_valid, hit, way, evict_valid;
  logic [1:0]  miss_class;
  logic [8:0]  evict_tag;
  logic [15:0] acc_cnt, hit_cnt;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  cmc_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .preload_i(preload), .req_valid_i(req_valid),
    .req_addr_i(req_addr), .resp_valid_o(resp_valid), .hit_o(hit),
    .miss_class_o(miss_class), .way_o(way), .evict_valid_o(evict_valid),
    .evict_tag_o(evict_tag), .access_cnt_o(acc_cnt), .hit_cnt_o(hit_cnt)
  );

  // reference model: timestamps, independent of the RTL structure
  int unsigned now;
  int unsigned d_tag[4][2];
  bit          d_v[4][2];
  int unsigned d_t[4][2];
  bit          m_seen[2048];
  int unsigned m_last[2048];
  int unsigned e_acc, e_hit;

  function automatic void m_reset();
    now = 0;
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin d_tag[s][w] = 0; d_v[s][w] = 0; d_t[s][w] = 0; end
    for (int b = 0; b < 2048; b++) begin m_seen[b] = 0; m_last[b] = 0; end
    e_acc = 0; e_hit = 0;
  endfunction

  function automatic void m_preload();
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin d_v[s][w] = 0; end
    for (int b = 0; b < 2048; b++) begin m_seen[b] = 0; m_last[b] = 0; end
    for (int b = 0; b < 8; b++) begin
      now++;
      d_tag[b % 4][b / 4] = b / 4; d_v[b % 4][b / 4] = 1; d_t[b % 4][b / 4] = now;
      m_seen[b] = 1; m_last[b] = now;
    end
  endfunction

  function automatic void m_access(input int unsigned addr, output bit h, output int cls,
                                   output int wy, output bit ev, output int et);
    int unsigned blk = addr >> 3;
    int s = blk % 4;
    int unsigned tg = blk / 4;
    int newer = 0;
    h = 0; wy = 0;
    for (int w = 0; w < 2; w++) if (d_v[s][w] && d_tag[s][w] == tg) begin h = 1; wy = w; end
    if (!h) begin
      if (!d_v[s][0])      wy = 0;
      else if (!d_v[s][1]) wy = 1;
      else                 wy = (d_t[s][0] < d_t[s][1]) ? 0 : 1;
    end
    ev = !h && d_v[s][wy];
    et = ev ? int'(d_tag[s][wy]) : 0;
    if (h) cls = 0;
    else if (!m_seen[blk]) cls = 1;
    else begin
      for (int b = 0; b < 2048; b++) if (m_seen[b] && m_last[b] > m_last[blk]) newer++;
      cls = (newer < 8) ? 3 : 2;
    end
    now++;
    d_tag[s][wy] = tg; d_v[s][wy] = 1; d_t[s][wy] = now;
    m_seen[blk] = 1; m_last[blk] = now;
    if (e_acc < 16'hFFFF) e_acc++;
    if (h && e_hit < 16'hFFFF) e_hit++;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  function automatic string cls_req(input int c);
    case (c)
      0: return "R3";
      1: return "R5";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  // drive one request at a negedge, check its response at the following negedge
  task automatic do_access(input logic [13:0] a, input string rq, output int cls_o);
    bit h, ev; int c, wy, et;
    req_valid = 1'b1; req_addr = a;
    m_access(a, h, c, wy, ev, et);
    @(negedge clk);
    req_valid = 1'b0;
    cls_o = c;
    chk(resp_valid == 1'b1, "R9", "resp_valid", resp_valid, 1);
    chk(hit == h && miss_class == c[1:0], (rq == "") ? cls_req(c) : rq, "hit*4+class",
        int'(hit) * 4 + int'(miss_class), int'(h) * 4 + c);
    chk(way == wy[0], "R4", "way", way, wy);
    chk(evict_valid == ev && evict_tag == et[8:0], "R10", "evict valid*1024+tag",
        int'(evict_valid) * 1024 + int'(evict_tag), int'(ev) * 1024 + et);
    chk(acc_cnt == e_acc[15:0] && hit_cnt == e_hit[15:0], "R11", "acc*65536+hit",
        int'(acc_cnt) * 65536 + int'(hit_cnt), int'(e_acc) * 65536 + int'(e_hit));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; preload = 1'b0; req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_reset();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int c;
    logic [13:0] seq[15];
    int exp_cls[15];
    void'($urandom(32'h5EED_0C4C));
    do_reset();

    // R1 reset state
    chk(resp_valid == 0, "R1", "resp_valid after reset", resp_valid, 0);
    chk(acc_cnt == 0 && hit_cnt == 0, "R1", "counters after reset", acc_cnt + hit_cnt, 0);

    // R1/R4/R5: cold set 0 fills way 0 then way 1, then evicts LRU (R3)
    do_access(14'h0000, "R1", c);
    chk(c == 1, "R5", "cold class", c, 1);
    do_access(14'h0005, "R2", c);          // same block, other offset -> hit
    chk(c == 0, "R2", "offset hit class", c, 0);
    do_access(14'h0020, "R4", c);          // tag 1, set 0 -> way 1
    do_access(14'h0000, "R3", c);          // refresh tag 0
    do_access(14'h0040, "R3", c);          // evicts tag 1 (way 1)
    chk(c == 1, "R5", "new block class", c, 1);

    // R9: idle cycle gives no response
    @(negedge clk);
    chk(resp_valid == 0, "R9", "idle resp_valid", resp_valid, 0);

    // R12: preload together with a request drops the request
    preload = 1'b1; req_valid = 1'b1; req_addr = 14'o0024;
    @(negedge clk);
    preload = 1'b0; req_valid = 1'b0;
    m_preload();
    chk(resp_valid == 0, "R12", "resp with preload", resp_valid, 0);
    chk(acc_cnt == e_acc[15:0], "R12", "acc count with preload", acc_cnt, e_acc);

    // R8: trace from the warm state with fixed classes
    seq = '{14'o0024, 14'o0100, 14'o0270, 14'o0570, 14'o0074, 14'o0272, 14'o0004, 14'o0044,
            14'o0640, 14'o0000, 14'o0410, 14'o0710, 14'o0550, 14'o0570, 14'o0410};
    exp_cls = '{0, 1, 1, 1, 3, 3, 2, 2, 1, 3, 1, 1, 1, 2, 3};
    for (int i = 0; i < 15; i++) begin
      do_access(seq[i], "", c);
      chk(miss_class == exp_cls[i][1:0], "R8", "warm trace class", miss_class, exp_cls[i]);
    end

    // constrained random mix, back to back
    for (int i = 0; i < 3000; i++) begin
      int unsigned b = ($urandom_range(0, 7) == 0) ? $urandom_range(0, 2047) : $urandom_range(0, 23);
      logic [13:0] a = {b[10:0], 3'($urandom_range(0, 7))};
      do_access(a, "", c);
      if ($urandom_range(0, 15) == 0) @(negedge clk);
    end

    // R11: saturation of both counters
    do_reset();
    req_valid = 1'b1; req_addr = 14'h0108;
    repeat (70000) @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(acc_cnt == 16'hFFFF, "R11", "access count saturated", acc_cnt, 16'hFFFF);
    chk(hit_cnt == 16'hFFFF, "R11", "hit count saturated", hit_cnt, 16'hFFFF);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule